// File: doc/BRIEF.md
# Router Coherence Tree Steering Unit

This block lives inside one router of a two-dimensional mesh and makes the routing decision for coherence requests passing through it. The coherence directory is not kept at a central home node. It is spread across the routers as one small virtual tree per active cache line. The tree links all point toward the line's root, which is the node that first fetched the line from memory. Each router keeps the tree entries it takes part in inside a small set-associative tree cache. An entry records the rootward parent direction, a mask of child directions, and whether the router's own node holds a copy.

A read or write request that finds no entry for its line is routed toward the line's home node. The home node is fixed by the low address bits, and the route goes along X first, then Y. A request that finds an entry is steered by the tree instead. A read goes to the local node when that node holds a copy; otherwise it climbs toward the root, which always has the data. A write becomes an invalidation fan-out over every tree link except the one it arrived on. Tree-maintenance messages install, update or remove entries and produce no output. Every routing decision appears on the registered output one clock after the request is presented.

Top module: `tvc_steer_top`

## Requirements
- R1: After synchronous active-low reset, `out_valid`, `out_port`, `out_hit` and `out_inv` are all zero and the tree cache holds no entries.
- R2: A read (`msg_type`=0) or write (`msg_type`=1) that misses leaves on the X-then-Y route to the home node, whose id is `msg_addr[3:0]` (x = id mod 4, y = id div 4). The one-hot port bits are: bit0 local, bit1 north (y+1), bit2 south (y-1), bit3 east (x+1), bit4 west (x-1). The local port is used when home equals this router (default x=1, y=2). On a miss `out_hit` is 0.
- R3: The decision for a request presented at one clock edge appears on the outputs after that edge, for one cycle. Without `msg_valid`, `out_valid` is 0 the next cycle.
- R4: A fill (`msg_type`=2) installs an entry for the line, with parent code `fill_parent`, child mask `fill_children` and local flag `fill_local`. A fill for a line already present overwrites that entry. A fill produces no output.
- R5: A read that hits an entry with the local flag set goes to the local port (bit0) with `out_hit`=1.
- R6: A read that hits an entry without the local flag goes out on the parent port. If the parent code is 7 (none, this router is the root), it goes to the local port. Direction codes are 0 local, 1 north, 2 south, 3 east, 4 west, 7 none.
- R7: A write that hits outputs the child mask ORed with the parent port, with the arrival port (`msg_in_dir`, same codes) cleared. `out_hit`=1 and `out_inv`=1.
- R8: A drop (`msg_type`=3) removes the line's entry and produces no output. Later requests for that line follow the home route.
- R9: The tree cache has 4 sets (`msg_addr[5:4]`) of 4 ways with tag `msg_addr[15:6]`. A fill into a full set replaces the least recently used way, where hits by reads, writes and fills count as use.
- R10: A lookup never matches more than one way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_valid | input | 1 | Message present this cycle |
| msg_type | input | 2 | 0 read, 1 write, 2 fill, 3 drop |
| msg_addr | input | 16 | Cache line address |
| msg_in_dir | input | 3 | Arrival direction code |
| fill_parent | input | 3 | Parent direction code for a fill |
| fill_children | input | 5 | Child port mask for a fill |
| fill_local | input | 1 | Local node holds a copy (fill) |
| out_valid | output | 1 | Routing decision valid |
| out_port | output | 5 | Output port request vector |
| out_hit | output | 1 | Request was steered by a tree entry |
| out_inv | output | 1 | Decision is a write invalidation fan-out |

## Verification
On every cycle the assertions check four things. A read or a missing request names exactly one port. A write fan-out never returns on its arrival port. Fill, drop and idle cycles give no output. The tree cache never matches twice and always has one clear replacement victim in a full set. Only the bench's scenarios can show that the chosen port is the correct one. These cover the X-then-Y direction for homes in every quadrant, the parent and root cases of a read, overwrite on refill, removal by drop, and which line a full set evicts.

// File: rtl/tvc_pkg.sv
// Shared codes for the coherence tree steering unit.
// Assumes five router ports in the fixed order local, north, south, east, west.
package tvc_pkg;
    localparam int PORTS = 5;

    typedef enum logic [1:0] {
        MSG_READ  = 2'd0,
        MSG_WRITE = 2'd1,
        MSG_FILL  = 2'd2,
        MSG_DROP  = 2'd3
    } msg_kind_e;

    localparam logic [2:0] DIR_LOCAL = 3'd0;
    localparam logic [2:0] DIR_NORTH = 3'd1;
    localparam logic [2:0] DIR_SOUTH = 3'd2;
    localparam logic [2:0] DIR_EAST  = 3'd3;
    localparam logic [2:0] DIR_WEST  = 3'd4;
    localparam logic [2:0] DIR_NONE  = 3'd7;

    // Direction code to one-hot port vector; codes beyond west give zero.
    function automatic logic [PORTS-1:0] dir_to_port(input logic [2:0] d);
        logic [PORTS-1:0] v;
        v = '0;
        if (int'(d) < PORTS) v[d] = 1'b1;
        return v;
    endfunction
endpackage

// File: rtl/tvc_xy_route.sv
// Default route toward a line's home node, X dimension first, then Y.
// Assumes MESH_X and MESH_Y are powers of two and node id = y*MESH_X + x.
module tvc_xy_route #(
    parameter int MESH_X = 4,
    parameter int MESH_Y = 4,
    parameter int HERE_X = 1,
    parameter int HERE_Y = 2,
    localparam int X_W    = $clog2(MESH_X),
    localparam int Y_W    = $clog2(MESH_Y),
    localparam int NODE_W = X_W + Y_W
) (
    input  logic [NODE_W-1:0]            home,
    output logic [tvc_pkg::PORTS-1:0]    port_oh
);
    import tvc_pkg::*;

    logic [X_W-1:0] hx;
    logic [Y_W-1:0] hy;

    assign hx = home[X_W-1:0];
    assign hy = home[NODE_W-1:X_W];

    // Pick the single output port of dimension-ordered routing.
    always_comb begin
        if (int'(hx) > HERE_X)      port_oh = dir_to_port(DIR_EAST);
        else if (int'(hx) < HERE_X) port_oh = dir_to_port(DIR_WEST);
        else if (int'(hy) > HERE_Y) port_oh = dir_to_port(DIR_NORTH);
        else if (int'(hy) < HERE_Y) port_oh = dir_to_port(DIR_SOUTH);
        else                        port_oh = dir_to_port(DIR_LOCAL);
    end
endmodule

// File: rtl/tvc_tree_store.sv
// Set-associative cache of per-line tree entries with age-based LRU.
// Lookup is combinational on set/tag; fills, drops and use updates land at
// the clock edge. Assumes WAYS is a power of two of at least 2.
module tvc_tree_store #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int TAG_W = 10,
    localparam int SET_W = $clog2(SETS),
    localparam int AGE_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SET_W-1:0]           lk_set,
    input  logic [TAG_W-1:0]           lk_tag,
    input  logic                       touch_en,
    input  logic                       fill_en,
    input  logic                       drop_en,
    input  logic [2:0]                 fill_parent,
    input  logic [tvc_pkg::PORTS-1:0]  fill_children,
    input  logic                       fill_local,
    output logic                       hit,
    output logic [2:0]                 hit_parent,
    output logic [tvc_pkg::PORTS-1:0]  hit_children,
    output logic                       hit_local
);
    import tvc_pkg::*;

    logic                 vld   [SETS][WAYS];
    logic [TAG_W-1:0]     tags  [SETS][WAYS];
    logic [2:0]           par   [SETS][WAYS];
    logic [PORTS-1:0]     kids  [SETS][WAYS];
    logic                 lcl   [SETS][WAYS];
    logic [AGE_W-1:0]     age   [SETS][WAYS];

    logic [WAYS-1:0]      hit_vec;
    logic [WAYS-1:0]      oldest_vec;
    logic [AGE_W-1:0]     hit_way;
    logic [AGE_W-1:0]     victim;
    logic [AGE_W-1:0]     use_way;
    logic                 set_full;
    logic                 do_touch;

    // Compare all ways of the selected set and collect the matching way.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            hit_vec[w]    = vld[lk_set][w] && (tags[lk_set][w] == lk_tag);
            oldest_vec[w] = (age[lk_set][w] == AGE_W'(WAYS - 1));
            if (hit_vec[w]) hit_way = AGE_W'(w);
        end
    end

    // Choose a fill victim: first empty way, else the least recently used.
    always_comb begin
        logic found;
        found    = 1'b0;
        victim   = '0;
        set_full = 1'b1;
        for (int w = 0; w < WAYS; w++) begin
            if (!vld[lk_set][w]) begin
                set_full = 1'b0;
                if (!found) begin
                    victim = AGE_W'(w);
                    found  = 1'b1;
                end
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++)
                if (oldest_vec[w]) victim = AGE_W'(w);
        end
    end

    assign hit          = |hit_vec;
    assign hit_parent   = par[lk_set][hit_way];
    assign hit_children = kids[lk_set][hit_way];
    assign hit_local    = lcl[lk_set][hit_way];
    assign use_way      = (fill_en && !hit) ? victim : hit_way;
    assign do_touch     = fill_en || (touch_en && hit);

    // Write entries, remove dropped ones and age the ways of the used set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++) begin
                    vld[s][w]  <= 1'b0;
                    tags[s][w] <= '0;
                    par[s][w]  <= DIR_NONE;
                    kids[s][w] <= '0;
                    lcl[s][w]  <= 1'b0;
                    age[s][w]  <= AGE_W'(w);
                end
        end else begin
            if (fill_en) begin
                vld[lk_set][use_way]  <= 1'b1;
                tags[lk_set][use_way] <= lk_tag;
                par[lk_set][use_way]  <= fill_parent;
                kids[lk_set][use_way] <= fill_children;
                lcl[lk_set][use_way]  <= fill_local;
            end else if (drop_en && hit) begin
                vld[lk_set][hit_way] <= 1'b0;
            end
            if (do_touch) begin
                for (int w = 0; w < WAYS; w++) begin
                    if (AGE_W'(w) == use_way)
                        age[lk_set][w] <= '0;
                    else if (age[lk_set][w] < age[lk_set][use_way])
                        age[lk_set][w] <= age[lk_set][w] + 1'b1;
                end
            end
        end
    end

    // R10: a tag lives in at most one way of its set.
    assert_single_match_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));

    // R9: ages stay a permutation, so a full set has exactly one oldest way.
    assert_unique_victim_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_full |-> $countones(oldest_vec) == 1);
endmodule

// File: rtl/tvc_steer_logic.sv
// Combinational steering choice: tree entry on a hit, home route on a miss.
// Assumes the caller has already filtered non-request message kinds.
module tvc_steer_logic (
    input  logic                       is_write,
    input  logic                       hit,
    input  logic [2:0]                 hit_parent,
    input  logic [tvc_pkg::PORTS-1:0]  hit_children,
    input  logic                       hit_local,
    input  logic [2:0]                 in_dir,
    input  logic [tvc_pkg::PORTS-1:0]  home_port,
    output logic [tvc_pkg::PORTS-1:0]  port_req,
    output logic                       inv_fanout
);
    import tvc_pkg::*;

    // Select read-toward-copy, write-fan-out or default home routing.
    always_comb begin
        inv_fanout = 1'b0;
        if (!hit) begin
            port_req = home_port;
        end else if (is_write) begin
            port_req   = (hit_children | dir_to_port(hit_parent)) & ~dir_to_port(in_dir);
            inv_fanout = 1'b1;
        end else if (hit_local || hit_parent == DIR_NONE) begin
            port_req = dir_to_port(DIR_LOCAL);
        end else begin
            port_req = dir_to_port(hit_parent);
        end
    end
endmodule

// File: rtl/tvc_steer_top.sv
// Coherence tree steering unit for one mesh router. Looks up the line of
// each message in the tree cache, decides the output ports and registers
// the decision (one cycle latency). Assumes one message per cycle and that
// the low address bits name the home node.
module tvc_steer_top #(
    parameter int MESH_X = 4,
    parameter int MESH_Y = 4,
    parameter int HERE_X = 1,
    parameter int HERE_Y = 2,
    parameter int ADDR_W = 16,
    parameter int SETS   = 4,
    parameter int WAYS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [1:0]        msg_type,
    input  logic [ADDR_W-1:0] msg_addr,
    input  logic [2:0]        msg_in_dir,
    input  logic [2:0]        fill_parent,
    input  logic [4:0]        fill_children,
    input  logic              fill_local,
    output logic              out_valid,
    output logic [4:0]        out_port,
    output logic              out_hit,
    output logic              out_inv
);
    import tvc_pkg::*;

    localparam int NODE_W = $clog2(MESH_X) + $clog2(MESH_Y);
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = ADDR_W - NODE_W - SET_W;

    logic                 is_read, is_write, is_fill, is_drop, is_req;
    logic                 hit, hit_local, inv_fanout;
    logic [2:0]           hit_parent;
    logic [PORTS-1:0]     hit_children, home_port, port_req;

    assign is_read  = msg_valid && msg_type == MSG_READ;
    assign is_write = msg_valid && msg_type == MSG_WRITE;
    assign is_fill  = msg_valid && msg_type == MSG_FILL;
    assign is_drop  = msg_valid && msg_type == MSG_DROP;
    assign is_req   = is_read || is_write;

    tvc_tree_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_set(msg_addr[NODE_W +: SET_W]),
        .lk_tag(msg_addr[ADDR_W-1 -: TAG_W]),
        .touch_en(is_req), .fill_en(is_fill), .drop_en(is_drop),
        .fill_parent(fill_parent), .fill_children(fill_children),
        .fill_local(fill_local),
        .hit(hit), .hit_parent(hit_parent), .hit_children(hit_children),
        .hit_local(hit_local)
    );

    tvc_xy_route #(.MESH_X(MESH_X), .MESH_Y(MESH_Y),
                   .HERE_X(HERE_X), .HERE_Y(HERE_Y)) u_route (
        .home(msg_addr[NODE_W-1:0]),
        .port_oh(home_port)
    );

    tvc_steer_logic u_steer (
        .is_write(is_write), .hit(hit), .hit_parent(hit_parent),
        .hit_children(hit_children), .hit_local(hit_local),
        .in_dir(msg_in_dir), .home_port(home_port),
        .port_req(port_req), .inv_fanout(inv_fanout)
    );

    // Register the routing decision for requests; other messages stay silent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_port  <= '0;
            out_hit   <= 1'b0;
            out_inv   <= 1'b0;
        end else begin
            out_valid <= is_req;
            out_port  <= is_req ? port_req : '0;
            out_hit   <= is_req && hit;
            out_inv   <= is_req && inv_fanout;
        end
    end

    // R3: no request in, no decision out next cycle.
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !msg_valid |=> !out_valid);

    // R4, R8: maintenance messages never raise a decision.
    assert_maint_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (is_fill || is_drop) |=> !out_valid);

    // R2, R5, R6: reads and misses request exactly one port.
    assert_single_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_inv) |-> $countones(out_port) == 1);

    // R7: an invalidation fan-out never goes back where it came from.
    assert_no_echo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_inv) |-> (out_port & dir_to_port($past(msg_in_dir))) == '0);
endmodule

// File: tb/tvc_steer_top_test.sv
// Directed bench for the coherence tree steering unit, 50 MHz clock.
module tvc_steer_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       msg_valid = 1'b0;
    logic [1:0] msg_type = '0;
    logic [15:0] msg_addr = '0;
    logic [2:0] msg_in_dir = '0;
    logic [2:0] fill_parent = '0;
    logic [4:0] fill_children = '0;
    logic       fill_local = 1'b0;
    logic       out_valid, out_hit, out_inv;
    logic [4:0] out_port;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    localparam int HX = 1;
    localparam int HY = 2;

    always #10 clk = ~clk;

    tvc_steer_top uut (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_type(msg_type),
        .msg_addr(msg_addr), .msg_in_dir(msg_in_dir), .fill_parent(fill_parent),
        .fill_children(fill_children), .fill_local(fill_local),
        .out_valid(out_valid), .out_port(out_port), .out_hit(out_hit),
        .out_inv(out_inv)
    );

    function automatic logic [15:0] mk_addr(input int tag, input int set, input int home);
        return {tag[9:0], set[1:0], home[3:0]};
    endfunction

    function automatic logic [4:0] port_of(input int code);
        return (code < 5) ? (5'd1 << code) : 5'd0;
    endfunction

    // Reference X-then-Y route from this router at (1,2) on a 4x4 mesh.
    function automatic logic [4:0] expect_xy(input int home);
        int x = home % 4;
        int y = home / 4;
        if (x > HX) return 5'b01000;
        if (x < HX) return 5'b10000;
        if (y > HY) return 5'b00010;
        if (y < HY) return 5'b00100;
        return 5'b00001;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Present one message for one edge and sample the outputs afterwards.
    task automatic send(input int kind, input logic [15:0] addr, input int in_dir,
                        input int par, input int kids, input bit lcl);
        @(negedge clk);
        msg_valid = 1'b1; msg_type = kind[1:0]; msg_addr = addr;
        msg_in_dir = in_dir[2:0]; fill_parent = par[2:0];
        fill_children = kids[4:0]; fill_local = lcl;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input bit v, input int port,
                              input bit h, input bit inv);
        check(req, "valid", int'(out_valid), int'(v));
        check(req, "port",  int'(out_port), port);
        check(req, "hit",   int'(out_hit), int'(h));
        check(req, "inv",   int'(out_inv), int'(inv));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        expect_out("R1", 0, 0, 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1", 0, 0, 0, 0);
    endtask

    task automatic t_miss_routes();
        int homes[6] = '{9, 3, 8, 13, 1, 0};
        foreach (homes[i]) begin
            send(0, mk_addr(5 + i, 0, homes[i]), 0, 0, 0, 0);
            expect_out("R2", 1, int'(expect_xy(homes[i])), 0, 0);
        end
        send(1, mk_addr(40, 1, 14), 4, 0, 0, 0);
        expect_out("R2", 1, int'(expect_xy(14)), 0, 0);
    endtask

    task automatic t_latency_idle();
        send(0, mk_addr(7, 2, 3), 0, 0, 0, 0);
        check("R3", "valid one cycle after", int'(out_valid), 1);
        @(negedge clk);
        check("R3", "valid drops when idle", int'(out_valid), 0);
        check("R3", "port clears when idle", int'(out_port), 0);
    endtask

    task automatic t_read_local();
        send(2, mk_addr(100, 0, 3), 0, 4, 5'b00010, 1);
        expect_out("R4", 0, 0, 0, 0);
        send(0, mk_addr(100, 0, 3), 2, 0, 0, 0);
        expect_out("R5", 1, 5'b00001, 1, 0);
    endtask

    task automatic t_read_parent();
        send(2, mk_addr(101, 1, 3), 0, 2, 5'b01000, 0);
        send(0, mk_addr(101, 1, 3), 3, 0, 0, 0);
        expect_out("R6", 1, int'(port_of(2)), 1, 0);
        send(2, mk_addr(102, 1, 8), 0, 7, 5'b00110, 0);
        send(0, mk_addr(102, 1, 8), 1, 0, 0, 0);
        expect_out("R6", 1, 5'b00001, 1, 0);
        send(2, mk_addr(101, 1, 3), 0, 1, 5'b01000, 0);
        send(0, mk_addr(101, 1, 3), 3, 0, 0, 0);
        expect_out("R4", 1, int'(port_of(1)), 1, 0);
    endtask

    task automatic t_write_fanout();
        logic [4:0] kids = 5'b00111;
        send(2, mk_addr(200, 2, 0), 0, 3, kids, 1);
        send(1, mk_addr(200, 2, 0), 1, 0, 0, 0);
        expect_out("R7", 1, int'((kids | port_of(3)) & ~port_of(1)), 1, 1);
        send(1, mk_addr(200, 2, 0), 3, 0, 0, 0);
        expect_out("R7", 1, int'((kids | port_of(3)) & ~port_of(3)), 1, 1);
    endtask

    task automatic t_drop();
        send(3, mk_addr(200, 2, 0), 0, 0, 0, 0);
        expect_out("R8", 0, 0, 0, 0);
        send(1, mk_addr(200, 2, 0), 1, 0, 0, 0);
        expect_out("R8", 1, int'(expect_xy(0)), 0, 0);
    endtask

    task automatic t_lru();
        for (int t = 20; t < 24; t++) send(2, mk_addr(t, 3, 3), 0, 7, 0, 0);
        send(0, mk_addr(20, 3, 3), 0, 0, 0, 0);
        check("R9", "refresh hit", int'(out_hit), 1);
        send(2, mk_addr(24, 3, 3), 0, 7, 0, 0);
        send(0, mk_addr(21, 3, 3), 0, 0, 0, 0);
        expect_out("R9", 1, int'(expect_xy(3)), 0, 0);
        for (int t = 20; t < 25; t++) begin
            if (t == 21) continue;
            send(0, mk_addr(t, 3, 3), 0, 0, 0, 0);
            expect_out("R9", 1, 5'b00001, 1, 0);
        end
    endtask

    initial begin
        for (int c = 0; c < 20000 && !finished; c++) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_miss_routes();
        t_latency_idle();
        t_read_local();
        t_read_parent();
        t_write_fanout();
        t_drop();
        t_lru();
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule